// File: doc/BRIEF.md
# Receiver PHY power-up sequencer

This block models how a serial camera receiver PHY is brought up and taken down. A small control sequencer owns the two active-low PHY controls, reset and shutdown, and keeps each in its own register. A power-up request releases reset first and releases shutdown a programmable number of cycles later. A power-down request drives shutdown low first, then reset. On that second step it also hands the internal access mode back to state-machine control.

While both controls are released, a state machine walks the PHY through its bias, calibration and lane-offset phases. Each phase lasts a programmable number of cycles. The walk ends in idle, and an ultra-low-power request can move the PHY from idle into a sleep state and back. The PHY reports ready in either of those two states. The termination-calibration result is taken from a 4-bit input at the moment the termination phase completes. It is kept, together with a done flag, for configuration reads.

The current state code and the calibration result are read through a combinational configuration read port.

Top module: `rxphy_pwr_seq`

## Requirements
- R1: Reset behaviour.
  - After synchronous reset, both PHY control outputs are low and the access-mode output is 0 (state-machine control).
  - The ready output is low.
  - Reads of addresses 0x01E, 0x220 and 0x221 all return 0.
- R2: Power-up order.
  - A power-up request seen while the PHY is off drives `phy_rst_n_o` high on the next clock edge.
  - `phy_shut_n_o` goes high GAP_CYCLES edges after that.
  - Shutdown is never released while reset is still asserted.
- R3: State codes are power-on 0, bandgap-on 1, calibration-type 2, burn-in 3, termination calibration 4, offset calibration 5, per-lane offset 6, idle 7, ultra-low-power 8, delay-line tuning 9 and skew-backward 10.
  - Once both controls are seen released, states 0 through 6 each last STEP_CYCLES cycles, in rising numeric order, and then the state becomes 7.
- R4: `phy_ready_o` is high exactly when the state code is 7 or 8.
- R5: Ultra-low-power requests.
  - While the state is 7 and `ulp_req` is high, the next state is 8.
  - While the state is 8 and `ulp_req` is low, the next state is 7.
  - `ulp_req` has no effect in any other state.
- R6: Whenever either PHY control output is low, the state returns to 0 on the next edge, including in the middle of calibration.
- R7: Power-down order.
  - A power-down request drives `phy_shut_n_o` low on the next edge while `phy_rst_n_o` stays high.
  - One edge later, `phy_rst_n_o` goes low and `access_host_o` returns to 0.
- R8: A read of address 0x01E returns the 4-bit state code in bits 3:0 and zeros above.
- R9: Termination-calibration capture.
  - `tcal_code_i` is captured on the edge where the state moves from 4 to 5, and the done flag is set on that same edge.
  - A read of 0x220 returns the captured code in bits 5:2 with all other bits 0.
  - A read of 0x221 returns the done flag in bit 7 with all other bits 0.
  - Leaving state 4 because of a power-down captures nothing.
- R10: Requests that do not start a sequence.
  - A host-access request sets `access_host_o` to 1 on the next edge.
  - A power-up request while the PHY is already on changes neither control output nor the state.
- R11: A read of any address other than 0x01E, 0x220 and 0x221 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| up_req | input | 1 | Power-up request pulse |
| down_req | input | 1 | Power-down request pulse, wins over power-up |
| host_mode_req | input | 1 | Hand internal access to the host |
| ulp_req | input | 1 | Ultra-low-power request level |
| tcal_code_i | input | CAL_W | Termination-calibration result from the analog side |
| cfg_addr | input | ADDR_W | Configuration read address |
| cfg_rdata | output | DATA_W | Configuration read data (combinational) |
| phy_rst_n_o | output | 1 | PHY reset control, active low |
| phy_shut_n_o | output | 1 | PHY shutdown control, active low |
| access_host_o | output | 1 | Access mode: 1 host, 0 state machine |
| phy_ready_o | output | 1 | PHY in idle or ultra-low-power |

## Verification
The bench sweeps the whole bring-up cycle by cycle against an arithmetic model of the state timeline. A design with an off-by-one dwell, a skipped state, or shutdown released together with reset would fail at the first edge where it differs from the model.

The calibration input changes every cycle with a different seed on each run. As a result, only a capture on exactly the edge leaving termination calibration gives the expected code, and a capture one cycle early or late reads back a neighbouring value. A power-down in the middle of termination calibration must return the state to 0 and leave the stored code alone; a design that captures whenever that state is left would overwrite it. An ultra-low-power request held throughout calibration must not let the machine leave the chain early, and power-down must drop shutdown a full cycle before reset.

// File: rtl/rxphy_pkg.sv
// Shared types and configuration addresses for the receiver PHY power-up
// sequencer. Assumes a 12-bit internal configuration address space.
package rxphy_pkg;

    // PHY state codes; the numeric values are visible through configuration reads
    typedef enum logic [3:0] {
        ST_PWRON   = 4'd0,
        ST_BIAS    = 4'd1,
        ST_CALSEL  = 4'd2,
        ST_BURNIN  = 4'd3,
        ST_TERM    = 4'd4,
        ST_OFFS    = 4'd5,
        ST_LANEOFS = 4'd6,
        ST_IDLE    = 4'd7,
        ST_ULP     = 4'd8,
        ST_DLYTUNE = 4'd9,
        ST_SKEWBK  = 4'd10
    } phy_state_e;

    // Phases of the reset/shutdown control sequencer
    typedef enum logic [1:0] {
        CTL_OFF,
        CTL_RELEASE,
        CTL_ON,
        CTL_DROP
    } ctl_phase_e;

    localparam logic [11:0] ADDR_STATE     = 12'h01E;
    localparam logic [11:0] ADDR_TCAL_CODE = 12'h220;
    localparam logic [11:0] ADDR_TCAL_FLAG = 12'h221;

endpackage

// File: rtl/rxphy_ctl_seq.sv
// Reset/shutdown control sequencer.
// Owns the two active-low PHY controls and the access-mode bit. Power-up
// releases reset, then shutdown GAP_CYCLES edges later. Power-down drops
// shutdown first and reset one edge later, returning access to the FSM.
// Assumes request inputs are synchronous single-cycle pulses; down wins.
module rxphy_ctl_seq
    import rxphy_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic down_req,
    input  logic host_mode_req,
    output logic phy_rst_n_o,
    output logic phy_shut_n_o,
    output logic access_host_o
);

    localparam int unsigned GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    ctl_phase_e       phase_q;
    logic             rstz_q;
    logic             shutz_q;
    logic             acc_q;
    logic [GAP_W-1:0] gap_cnt_q;

    // Sequence the two control registers through off, release, on and drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= CTL_OFF;
            rstz_q    <= 1'b0;
            shutz_q   <= 1'b0;
            gap_cnt_q <= '0;
        end else begin
            unique case (phase_q)
                CTL_OFF: begin
                    if (up_req && !down_req) begin
                        phase_q   <= CTL_RELEASE;
                        rstz_q    <= 1'b1;
                        gap_cnt_q <= '0;
                    end
                end
                CTL_RELEASE, CTL_ON: begin
                    if (down_req) begin
                        shutz_q <= 1'b0;
                        phase_q <= CTL_DROP;
                    end else if (phase_q == CTL_RELEASE) begin
                        if (gap_cnt_q == GAP_LAST) begin
                            shutz_q <= 1'b1;
                            phase_q <= CTL_ON;
                        end else begin
                            gap_cnt_q <= gap_cnt_q + 1'b1;
                        end
                    end
                end
                CTL_DROP: begin
                    rstz_q  <= 1'b0;
                    phase_q <= CTL_OFF;
                end
                default: phase_q <= CTL_OFF;
            endcase
        end
    end

    // Track the access mode: host on request, state machine after power-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
        end else if (phase_q == CTL_DROP) begin
            acc_q <= 1'b0;
        end else if (host_mode_req) begin
            acc_q <= 1'b1;
        end
    end

    assign phy_rst_n_o   = rstz_q;
    assign phy_shut_n_o  = shutz_q;
    assign access_host_o = acc_q;

    // R2: shutdown is never released while reset is held
    assert_shut_needs_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shutz_q |-> rstz_q);

    // R7: reset only falls after shutdown was already low
    assert_rst_after_shut_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rstz_q) |-> ($past(shutz_q) == 1'b0));

    // R7: a power-down hands access back to the state machine
    assert_access_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rstz_q) |-> !acc_q);

endmodule

// File: rtl/rxphy_pwr_fsm.sv
// PHY power state machine.
// While both controls are released, walks states 0..6 in order, each for
// STEP_CYCLES cycles, then rests in idle; ulp_req toggles idle and sleep.
// Either control low forces power-on. Assumes STEP_CYCLES >= 1.
module rxphy_pwr_fsm
    import rxphy_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_rst_n,
    input  logic       ctl_shut_n,
    input  logic       ulp_req,
    output phy_state_e state_o,
    output logic       step_o,
    output logic       ready_o
);

    localparam int unsigned STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);

    phy_state_e        state_q;
    logic [STEP_W-1:0] dwell_q;
    logic              enable;
    logic              in_chain;

    // Decode run enable and the end-of-dwell strobe for the calibration chain
    always_comb begin
        enable   = ctl_rst_n && ctl_shut_n;
        in_chain = (state_q < ST_IDLE);
        step_o   = enable && in_chain && (dwell_q == STEP_LAST);
    end

    // Advance the state and dwell counter
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= ST_PWRON;
            dwell_q <= '0;
        end else if (in_chain) begin
            if (step_o) begin
                state_q <= phy_state_e'(state_q + 4'd1);
                dwell_q <= '0;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (ulp_req)  state_q <= ST_ULP;
                ST_ULP:  if (!ulp_req) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign ready_o = (state_q == ST_IDLE) || (state_q == ST_ULP);

    // R6: any asserted control returns the machine to power-on
    assert_ctl_forces_pwron_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rst_n && ctl_shut_n) |=> (state_q == ST_PWRON));

    // R3: up to idle, every change of state is a step of one code
    assert_chain_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != $past(state_q)) && (state_q != ST_PWRON) &&
         ($past(state_q) != ST_ULP)) |-> (state_q == phy_state_e'($past(state_q) + 4'd1)));

    // R5: sleep is entered only from idle
    assert_ulp_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ULP) |-> (($past(state_q) == ST_IDLE) || ($past(state_q) == ST_ULP)));

endmodule

// File: rtl/rxphy_tcal_store.sv
// Termination-calibration result store.
// Captures the calibration code on the edge that completes the termination
// phase and sets a done flag; both persist until block reset.
module rxphy_tcal_store
    import rxphy_pkg::*;
#(
    parameter int unsigned CAL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phy_state_e       state_i,
    input  logic             step_i,
    input  logic [CAL_W-1:0] cal_code_i,
    output logic [CAL_W-1:0] code_o,
    output logic             done_o
);

    logic [CAL_W-1:0] code_q;
    logic             done_q;
    logic             capture;

    // Capture only on normal completion of termination calibration
    assign capture = step_i && (state_i == ST_TERM);

    // Hold the captured code and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else if (capture) begin
            code_q <= cal_code_i;
            done_q <= 1'b1;
        end
    end

    assign code_o = code_q;
    assign done_o = done_q;

    // R9: the flag first rises as the machine moves from 4 to 5
    assert_flag_on_term_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (($past(state_i) == ST_TERM) && (state_i == ST_OFFS)));

    // R9: a stored code only changes on a capture edge
    assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !capture) |=> $stable(code_q));

endmodule

// File: rtl/rxphy_cfg_rd.sv
// Combinational configuration read decoder.
// Maps the state code, calibration code and done flag onto three internal
// addresses; all other addresses read as zero. Assumes DATA_W >= 8.
module rxphy_cfg_rd
    import rxphy_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CAL_W  = 4
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  phy_state_e        state_i,
    input  logic [CAL_W-1:0]  code_i,
    input  logic              done_i,
    output logic [DATA_W-1:0] cfg_rdata
);

    localparam int unsigned CODE_LSB = 2;
    localparam int unsigned FLAG_BIT = 7;

    // Select read data by address
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_W'(ADDR_STATE)) begin
            cfg_rdata = DATA_W'(state_i);
        end else if (cfg_addr == ADDR_W'(ADDR_TCAL_CODE)) begin
            cfg_rdata = DATA_W'(code_i) << CODE_LSB;
        end else if (cfg_addr == ADDR_W'(ADDR_TCAL_FLAG)) begin
            cfg_rdata[FLAG_BIT] = done_i;
        end
    end

endmodule

// File: rtl/rxphy_pwr_seq.sv
// Receiver PHY power-up sequencer, top level.
// Connects the control sequencer, the power state machine, the calibration
// store and the configuration read decoder. Synchronous active-low reset.
module rxphy_pwr_seq
    import rxphy_pkg::*;
#(
    parameter int unsigned GAP_CYCLES  = 16,
    parameter int unsigned STEP_CYCLES = 64,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CAL_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              down_req,
    input  logic              host_mode_req,
    input  logic              ulp_req,
    input  logic [CAL_W-1:0]  tcal_code_i,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              phy_rst_n_o,
    output logic              phy_shut_n_o,
    output logic              access_host_o,
    output logic              phy_ready_o
);

    phy_state_e       state;
    logic             step;
    logic [CAL_W-1:0] cal_code;
    logic             cal_done;

    rxphy_ctl_seq #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_req        (up_req),
        .down_req      (down_req),
        .host_mode_req (host_mode_req),
        .phy_rst_n_o   (phy_rst_n_o),
        .phy_shut_n_o  (phy_shut_n_o),
        .access_host_o (access_host_o)
    );

    rxphy_pwr_fsm #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_rst_n  (phy_rst_n_o),
        .ctl_shut_n (phy_shut_n_o),
        .ulp_req    (ulp_req),
        .state_o    (state),
        .step_o     (step),
        .ready_o    (phy_ready_o)
    );

    rxphy_tcal_store #(
        .CAL_W (CAL_W)
    ) u_tcal (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .step_i     (step),
        .cal_code_i (tcal_code_i),
        .code_o     (cal_code),
        .done_o     (cal_done)
    );

    rxphy_cfg_rd #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CAL_W  (CAL_W)
    ) u_rd (
        .cfg_addr  (cfg_addr),
        .state_i   (state),
        .code_i    (cal_code),
        .done_i    (cal_done),
        .cfg_rdata (cfg_rdata)
    );

    // R4: ready is reported only in idle or sleep
    assert_ready_states_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ready_o |-> ((state == ST_IDLE) || (state == ST_ULP)));

endmodule

// File: tb/rxphy_pwr_seq_test.sv
`timescale 1ns/1ps
module rxphy_pwr_seq_test;

    localparam int GAP   = 3;
    localparam int STEP  = 4;
    localparam int TOTAL = GAP + 7 * STEP;
    localparam int TLAT  = GAP + 5 * STEP;

    localparam logic [11:0] A_STATE = 12'h01E;
    localparam logic [11:0] A_CODE  = 12'h220;
    localparam logic [11:0] A_FLAG  = 12'h221;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0;
    logic        down_req = 1'b0;
    logic        host_mode_req = 1'b0;
    logic        ulp_req = 1'b0;
    logic [3:0]  tcal_code_i = 4'd0;
    logic [11:0] cfg_addr = 12'h000;
    logic [7:0]  cfg_rdata;
    logic        phy_rst_n_o;
    logic        phy_shut_n_o;
    logic        access_host_o;
    logic        phy_ready_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_code = 0;

    always #2 clk = ~clk;

    rxphy_pwr_seq #(
        .GAP_CYCLES  (GAP),
        .STEP_CYCLES (STEP)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_req        (up_req),
        .down_req      (down_req),
        .host_mode_req (host_mode_req),
        .ulp_req       (ulp_req),
        .tcal_code_i   (tcal_code_i),
        .cfg_addr      (cfg_addr),
        .cfg_rdata     (cfg_rdata),
        .phy_rst_n_o   (phy_rst_n_o),
        .phy_shut_n_o  (phy_shut_n_o),
        .access_host_o (access_host_o),
        .phy_ready_o   (phy_ready_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        cfg_addr = a;
        #0.5;
        d = cfg_rdata;
    endtask

    function automatic int exp_state(input int t, input bit ulp);
        int s;
        if (t <= GAP) s = 0;
        else s = (t - GAP) / STEP;
        if (s > 7) s = 7;
        if (ulp && t > TOTAL) s = 8;
        return s;
    endfunction

    // Full bring-up swept cycle by cycle; t counts edges since the request edge
    task automatic run_up(input int seed, input bit ulp, input bit first);
        logic [7:0] d;
        int es;
        @(negedge clk);
        up_req  = 1'b1;
        ulp_req = ulp;
        tcal_code_i = 4'(seed);
        @(negedge clk);
        up_req = 1'b0;
        for (int t = 0; t <= TOTAL + 2; t++) begin
            es = exp_state(t, ulp);
            chk("R2 reset released", 32'(phy_rst_n_o), 32'd1);
            chk("R2 shutdown gap", 32'(phy_shut_n_o), 32'(t >= GAP));
            rd(A_STATE, d);
            chk(ulp ? "R5 state with ulp held" : "R3/R8 state code", 32'(d), 32'(es));
            chk("R4 ready", 32'(phy_ready_o), 32'(es >= 7));
            if (first && t == TLAT - 1) begin
                rd(A_FLAG, d);
                chk("R9 flag before capture", 32'(d), 32'd0);
            end
            tcal_code_i = 4'((t + 1) * 7 + seed);
            cfg_addr = A_STATE;
            @(negedge clk);
        end
        exp_code = (TLAT * 7 + seed) & 15;
        rd(A_CODE, d);
        chk("R9 captured code", 32'(d), 32'(exp_code << 2));
        rd(A_FLAG, d);
        chk("R9 done flag", 32'(d), 32'h80);
    endtask

    task automatic power_down();
        logic [7:0] d;
        logic [7:0] s0;
        rd(A_STATE, s0);
        down_req = 1'b1;
        @(negedge clk);
        down_req = 1'b0;
        chk("R7 shutdown first", 32'(phy_shut_n_o), 32'd0);
        chk("R7 reset still high", 32'(phy_rst_n_o), 32'd1);
        rd(A_STATE, d);
        chk("R7 state held one edge", 32'(d), 32'(s0));
        @(negedge clk);
        chk("R7 reset second", 32'(phy_rst_n_o), 32'd0);
        chk("R7 access to fsm", 32'(access_host_o), 32'd0);
        rd(A_STATE, d);
        chk("R6 state to power-on", 32'(d), 32'd0);
        chk("R4 ready low off", 32'(phy_ready_o), 32'd0);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset ctl", 32'(phy_rst_n_o), 32'd0);
        chk("R1 shutdown ctl", 32'(phy_shut_n_o), 32'd0);
        chk("R1 access", 32'(access_host_o), 32'd0);
        chk("R1 ready", 32'(phy_ready_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_STATE, d); chk("R1 state read", 32'(d), 32'd0);
        rd(A_CODE, d);  chk("R1 code read", 32'(d), 32'd0);
        rd(A_FLAG, d);  chk("R1 flag read", 32'(d), 32'd0);

        // R2/R3/R9 first bring-up
        run_up(0, 1'b0, 1'b1);

        // R10 power-up while on is ignored
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        @(negedge clk);
        chk("R10 up ignored rst", 32'(phy_rst_n_o), 32'd1);
        chk("R10 up ignored shut", 32'(phy_shut_n_o), 32'd1);
        rd(A_STATE, d); chk("R10 up ignored state", 32'(d), 32'd7);

        // R10 host access request
        host_mode_req = 1'b1;
        @(negedge clk);
        host_mode_req = 1'b0;
        chk("R10 host access", 32'(access_host_o), 32'd1);

        // R11 unmapped addresses
        rd(12'h01F, d); chk("R11 unmapped 0x01F", 32'(d), 32'd0);
        rd(12'h000, d); chk("R11 unmapped 0x000", 32'(d), 32'd0);
        rd(12'h222, d); chk("R11 unmapped 0x222", 32'(d), 32'd0);
        rd(12'hFFF, d); chk("R11 unmapped 0xFFF", 32'(d), 32'd0);

        // R5 sleep entry and exit
        ulp_req = 1'b1;
        @(negedge clk);
        rd(A_STATE, d); chk("R5 enter ulp", 32'(d), 32'd8);
        chk("R4 ready in ulp", 32'(phy_ready_o), 32'd1);
        repeat (3) @(negedge clk);
        rd(A_STATE, d); chk("R5 ulp held", 32'(d), 32'd8);
        ulp_req = 1'b0;
        @(negedge clk);
        rd(A_STATE, d); chk("R5 leave ulp", 32'(d), 32'd7);

        // R7 power-down order from idle
        power_down();

        // second bring-up with sleep requested throughout, new seed
        run_up(5, 1'b1, 1'b0);
        ulp_req = 1'b0;
        @(negedge clk);
        rd(A_STATE, d); chk("R5 back to idle", 32'(d), 32'd7);
        power_down();

        // R6/R9 power-down in the middle of termination calibration
        up_req = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        repeat (GAP + 4 * STEP + 1) @(negedge clk);
        rd(A_STATE, d); chk("R6 in termination cal", 32'(d), 32'd4);
        tcal_code_i = 4'(exp_code + 3);
        down_req = 1'b1;
        @(negedge clk);
        down_req = 1'b0;
        tcal_code_i = 4'(exp_code + 9);
        @(negedge clk);
        rd(A_STATE, d); chk("R6 aborted to power-on", 32'(d), 32'd0);
        repeat (STEP + 2) @(negedge clk);
        rd(A_STATE, d); chk("R6 stays off", 32'(d), 32'd0);
        rd(A_CODE, d); chk("R9 no capture on abort", 32'(d), 32'(exp_code << 2));
        rd(A_FLAG, d); chk("R9 flag kept", 32'(d), 32'h80);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule